// File: doc/BRIEF.md
# RTC interrupt flag controller

This block holds the interrupt state of a real-time clock. Three event sources, the periodic tick, the alarm match and the end of a time update, each send a one-cycle pulse. Each pulse sets a sticky flag of its own. A flag is set whether or not its source is enabled. The three enable bits are combined with the flags into one summary bit. While the summary bit is set, the block asks an open-drain driver to pull the shared interrupt line low. When the summary bit is clear, the driver is released and the line floats.

Software uses two register-style ports. A write port loads the three enable bits and the square-wave enable. A read port returns the status byte. Every accepted status read clears the event flags, which releases the interrupt line. The read returns the values held before the clear. A device-level active-low hold input clears the enables, the flags and the square-wave enable, but only while main power is good. While the hold input is low, bus access is blocked. While power is failing, bus access is also blocked and all state is kept, whatever the hold input does.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After the synchronous system reset (`rst_n` low), `int_en`, `sqw_en`, `irq_oe` and `rd_valid` are all 0, and a status read returns 0x00.
- R2: A pulse on `ev_periodic`, `ev_alarm` or `ev_update` sets its flag from the next cycle, whatever the state of its enable bit. In the status byte, bit 6 is the periodic flag, bit 5 is the alarm flag and bit 4 is the update flag.
- R3: `irq_oe` is 1 exactly while at least one flag is set together with its matching enable bit. In the status byte this summary appears in bit 7. Bits 3..0 always read 0.
- R4: An accepted write loads the enables from `wr_data`: bit 6 is the periodic enable, bit 5 is the alarm enable, bit 4 is the update enable and bit 3 is the square-wave enable. The bits 7 and 2..0 have no effect. The values show on `int_en` (index 2 periodic, 1 alarm, 0 update) and `sqw_en` from the next cycle.
- R5: An accepted status read (`rd_en` high) returns the status byte on `rd_data` one cycle later, with `rd_valid` high for that one cycle. The value is the one held before the read cleared anything.
- R6: An accepted status read clears all three flags, and `irq_oe` is 0 in the next cycle unless a new event arrived.
- R7: An event pulse in the same cycle as an accepted status read leaves its flag set after the read.
- R8: While `hold_n` is low and `pwr_ok` is high, the enables, the flags, the summary bit and `sqw_en` are forced to 0, and event pulses do not set flags.
- R9: While `hold_n` is low, writes are ignored and reads produce no `rd_valid`.
- R10: While `pwr_ok` is low, writes and reads are ignored, and the enables and `sqw_en` keep their values even if `hold_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| hold_n | input | 1 | Device hold input, active low |
| pwr_ok | input | 1 | High while main supply is above the power-fail threshold |
| ev_periodic | input | 1 | One-cycle periodic event pulse |
| ev_alarm | input | 1 | One-cycle alarm event pulse |
| ev_update | input | 1 | One-cycle update-ended event pulse |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| rd_en | input | 1 | Status register read strobe |
| rd_data | output | 8 | Status byte, valid with rd_valid |
| rd_valid | output | 1 | High for one cycle when rd_data holds a read result |
| int_en | output | 3 | Enable bits: [2] periodic, [1] alarm, [0] update |
| sqw_en | output | 1 | Square-wave output enable |
| irq_oe | output | 1 | Pull-down enable of the open-drain interrupt line |

## Verification
The hardest case to reach is an event pulse that lands in the exact cycle a status read is accepted. In that cycle the clear and the set compete for the same flag. The stimulus raises `ev_alarm` and `rd_en` on the same edge. It then expects the read to return the earlier flags, and a second read to still find the alarm flag set. A second hard case is the power-fail window with the hold input low, where the state must not be cleared. The stimulus lowers `pwr_ok` before `hold_n` and raises `pwr_ok` only after `hold_n` is high again, so the hold never acts while power is good.

// File: rtl/rtc_irq_pkg.sv
// Package: rtc_irq_pkg
// Shared constants for the RTC interrupt flag controller. It fixes the
// source ordering that is used in every flag and enable vector, and the
// bit positions of the control and status bytes.
// Assumes: a byte-wide register bus.
package rtc_irq_pkg;
    localparam int SRC_N    = 3;   // number of interrupt sources
    localparam int SRC_UPD  = 0;   // index of the update-ended source
    localparam int SRC_ALM  = 1;   // index of the alarm source
    localparam int SRC_PER  = 2;   // index of the periodic source
    localparam int BUS_W    = 8;   // register width
    localparam int EN_LSB   = 4;   // control byte: lowest enable bit
    localparam int SQWE_BIT = 3;   // control byte: square-wave enable bit
endpackage

// File: rtl/rtc_irq_gate.sv
// Module: rtc_irq_gate
// Decides, from the hold input and the power-good level, whether the
// bus strobes are accepted and whether the hold clear is applied.
// Assumes: hold_n and pwr_ok are already synchronous to clk.
module rtc_irq_gate (
    input  logic hold_n,
    input  logic pwr_ok,
    input  logic rd_en,
    input  logic wr_en,
    output logic force_clr,
    output logic rd_ok,
    output logic wr_ok
);
    logic bus_open;

    // Access is allowed only with power good and the hold released.
    always_comb begin
        bus_open  = hold_n && pwr_ok;
        force_clr = !hold_n && pwr_ok;
        rd_ok     = bus_open && rd_en;
        wr_ok     = bus_open && wr_en;
    end
endmodule

// File: rtl/rtc_irq_flags.sv
// Module: rtc_irq_flags
// Bank of sticky event flags, one per source. Each flag is set by its
// pulse, cleared by an accepted status read, and forced low by the hold
// clear. A pulse in the same cycle as a read wins over the clear.
// Assumes: event pulses are one cycle wide and synchronous to clk.
module rtc_irq_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         force_clr,
    input  logic         rd_clr,
    input  logic [N-1:0] ev,
    output logic [N-1:0] flag_q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // One sticky flag: the hold clear first, then a pulse, then the read clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[i] <= 1'b0;
            end else if (force_clr) begin
                flag_q[i] <= 1'b0;
            end else if (ev[i]) begin
                flag_q[i] <= 1'b1;
            end else if (rd_clr) begin
                flag_q[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rtc_irq_ctlreg.sv
// Module: rtc_irq_ctlreg
// Control register that holds the per-source interrupt enables and the
// square-wave enable. It is loaded from the write port and cleared by
// the hold clear. The other bits of the write data are ignored.
// Assumes: the enable field and the square-wave bit lie inside the bus width.
module rtc_irq_ctlreg #(
    parameter int DW       = 8,
    parameter int N        = 3,
    parameter int EN_LSB   = 4,
    parameter int SQWE_BIT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          force_clr,
    input  logic          wr_ok,
    input  logic [DW-1:0] wr_data,
    output logic [N-1:0]  en_q,
    output logic          sqwe_q
);
    localparam logic [DW-1:0] EN_MASK   = {{(DW-N){1'b0}}, {N{1'b1}}} << EN_LSB;
    localparam logic [DW-1:0] SQWE_MASK = {{(DW-1){1'b0}}, 1'b1} << SQWE_BIT;
    localparam logic [DW-1:0] USED_MASK = EN_MASK | SQWE_MASK;

    logic unused_wr_bits;

    // The bits of the write data that control nothing.
    assign unused_wr_bits = ^(wr_data & ~USED_MASK);

    // Load on a write, clear on the hold, keep otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            sqwe_q <= 1'b0;
        end else if (force_clr) begin
            en_q   <= '0;
            sqwe_q <= 1'b0;
        end else if (wr_ok) begin
            en_q   <= wr_data[EN_LSB +: N];
            sqwe_q <= wr_data[SQWE_BIT];
        end
    end
endmodule

// File: rtl/rtc_irq_status.sv
// Module: rtc_irq_status
// Forms the summary bit from the flags and enables, and captures the
// status byte on an accepted read, before that read clears the flags.
// Assumes: DW is larger than N and leaves room for the summary bit.
module rtc_irq_status #(
    parameter int DW = 8,
    parameter int N  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_ok,
    input  logic [N-1:0]  flag_q,
    input  logic [N-1:0]  en_q,
    output logic          irqf,
    output logic [DW-1:0] rd_data_q,
    output logic          rd_valid_q
);
    localparam int PAD = DW - 1 - N;

    // Summary: any flag together with its enable.
    assign irqf = |(flag_q & en_q);

    // Capture the status byte, with the values from before the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_q  <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            rd_valid_q <= rd_ok;
            if (rd_ok) begin
                rd_data_q <= {irqf, flag_q, {PAD{1'b0}}};
            end
        end
    end
endmodule

// File: rtl/rtc_irq_ctrl.sv
// Module: rtc_irq_ctrl
// Top of the RTC interrupt flag controller. It gates the bus strobes,
// holds the flags and the enables, and drives the pull-down enable of the
// open-drain interrupt line from the summary bit.
// Assumes: every input is synchronous to clk. rst_n is the system reset.
// hold_n is the device hold input.
module rtc_irq_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold_n,
    input  logic       pwr_ok,
    input  logic       ev_periodic,
    input  logic       ev_alarm,
    input  logic       ev_update,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       rd_valid,
    output logic [2:0] int_en,
    output logic       sqw_en,
    output logic       irq_oe
);
    import rtc_irq_pkg::*;

    logic             force_clr;
    logic             rd_ok;
    logic             wr_ok;
    logic [SRC_N-1:0] ev_vec;
    logic [SRC_N-1:0] flag_q;
    logic [SRC_N-1:0] en_q;
    logic             sqwe_q;
    logic             irqf;

    // Put the event pulses into the shared source order.
    always_comb begin
        ev_vec          = '0;
        ev_vec[SRC_PER] = ev_periodic;
        ev_vec[SRC_ALM] = ev_alarm;
        ev_vec[SRC_UPD] = ev_update;
    end

    rtc_irq_gate u_gate (
        .hold_n    (hold_n),
        .pwr_ok    (pwr_ok),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .force_clr (force_clr),
        .rd_ok     (rd_ok),
        .wr_ok     (wr_ok)
    );

    rtc_irq_flags #(.N(SRC_N)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .force_clr (force_clr),
        .rd_clr    (rd_ok),
        .ev        (ev_vec),
        .flag_q    (flag_q)
    );

    rtc_irq_ctlreg #(
        .DW       (BUS_W),
        .N        (SRC_N),
        .EN_LSB   (EN_LSB),
        .SQWE_BIT (SQWE_BIT)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .force_clr (force_clr),
        .wr_ok     (wr_ok),
        .wr_data   (wr_data),
        .en_q      (en_q),
        .sqwe_q    (sqwe_q)
    );

    rtc_irq_status #(.DW(BUS_W), .N(SRC_N)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_ok      (rd_ok),
        .flag_q     (flag_q),
        .en_q       (en_q),
        .irqf       (irqf),
        .rd_data_q  (rd_data),
        .rd_valid_q (rd_valid)
    );

    // Drive the outputs from the register state.
    always_comb begin
        int_en = en_q;
        sqw_en = sqwe_q;
        irq_oe = irqf;
    end
endmodule

// File: rtl/rtc_irq_ctrl_chk.sv
// Module: rtc_irq_ctrl_chk
// Property checker for rtc_irq_ctrl, attached with bind. It watches the
// ports and the internal flag vector.
module rtc_irq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hold_n,
    input logic       pwr_ok,
    input logic       ev_periodic,
    input logic       ev_alarm,
    input logic       ev_update,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       rd_en,
    input logic       rd_valid,
    input logic [2:0] int_en,
    input logic       sqw_en,
    input logic       irq_oe,
    input logic [2:0] flag_q
);
    logic [2:0] ev_vec;
    assign ev_vec = {ev_periodic, ev_alarm, ev_update};

    // R2: a pulse outside the hold clear sets its flag.
    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ev_vec) && !(!hold_n && pwr_ok)) |=> ((flag_q & $past(ev_vec)) == $past(ev_vec)));

    // R3: the interrupt is requested only for an enabled pending flag.
    a_r3_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq_oe |-> (|(flag_q & int_en)));

    // R4: an accepted write loads the enables and the square-wave bit.
    a_r4_write_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hold_n && pwr_ok) |=> (int_en == $past(wr_data[6:4]) && sqw_en == $past(wr_data[3])));

    // R6: a read with no new event releases the interrupt.
    a_r6_read_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hold_n && pwr_ok && !(|ev_vec)) |=> !irq_oe);

    // R8: the hold with power good clears the state.
    a_r8_hold_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_n && pwr_ok) |=> (int_en == 3'b000 && !sqw_en && !irq_oe && flag_q == 3'b000));

    // R9: no read result follows a held cycle.
    a_r9_hold_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_n |=> !rd_valid);

    // R10: the enables are kept during power fail.
    a_r10_pf_keep: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> ($stable(int_en) && $stable(sqw_en) && !rd_valid));
endmodule

bind rtc_irq_ctrl rtc_irq_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold_n      (hold_n),
    .pwr_ok      (pwr_ok),
    .ev_periodic (ev_periodic),
    .ev_alarm    (ev_alarm),
    .ev_update   (ev_update),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_en       (rd_en),
    .rd_valid    (rd_valid),
    .int_en      (int_en),
    .sqw_en      (sqw_en),
    .irq_oe      (irq_oe),
    .flag_q      (flag_q)
);

// File: tb/rtc_irq_ctrl_test.sv
// Bench: rtc_irq_ctrl_test
// Scoreboard bench. The read task pushes the expected status byte and the
// monitor pops it and compares it when rd_valid shows the result.
module rtc_irq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hold_n = 1'b1;
    logic       pwr_ok = 1'b1;
    logic       ev_periodic = 1'b0;
    logic       ev_alarm = 1'b0;
    logic       ev_update = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic [2:0] int_en;
    logic       sqw_en;
    logic       irq_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    rtc_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .hold_n(hold_n), .pwr_ok(pwr_ok),
        .ev_periodic(ev_periodic), .ev_alarm(ev_alarm), .ev_update(ev_update),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .rd_valid(rd_valid), .int_en(int_en),
        .sqw_en(sqw_en), .irq_oe(irq_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic pulse(input bit p, input bit a, input bit u);
        ev_periodic = p; ev_alarm = a; ev_update = u;
        tick();
        ev_periodic = 0; ev_alarm = 0; ev_update = 0;
    endtask

    task automatic write_ctl(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        tick();
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic read_stat(input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
        tick();
    endtask

    task automatic read_ignored(input string tag);
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
        check(tag, {7'd0, rd_valid}, 8'h00);
    endtask

    // Monitor: compare each read result with the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check("R5 unexpected rd_valid", 8'h01, 8'h00);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: the reset state
        check("R1 int_en", {5'd0, int_en}, 8'h00);
        check("R1 sqw_en", {7'd0, sqw_en}, 8'h00);
        check("R1 irq_oe", {7'd0, irq_oe}, 8'h00);
        check("R1 rd_valid", {7'd0, rd_valid}, 8'h00);
        read_stat(8'h00, "R1 R5 status after reset");

        // R2: a flag is set with its enable off; R3: no interrupt
        pulse(1, 0, 0);
        check("R3 disabled source no irq", {7'd0, irq_oe}, 8'h00);
        read_stat(8'h40, "R2 periodic flag bit6");
        read_stat(8'h00, "R6 flags cleared by read");

        // R4: enable fields
        write_ctl(8'hFF);
        check("R4 all enables", {4'd0, sqw_en, int_en}, 8'h0F);
        write_ctl(8'h87);
        check("R4 ignored bits", {4'd0, sqw_en, int_en}, 8'h00);
        write_ctl(8'h20);
        check("R4 alarm only", {5'd0, int_en}, 8'h02);

        // R3: the summary follows only the enabled flag
        pulse(0, 0, 1);
        check("R3 update not enabled", {7'd0, irq_oe}, 8'h00);
        pulse(0, 1, 0);
        check("R3 alarm enabled irq", {7'd0, irq_oe}, 8'h01);
        exp_q.push_back(8'hB0); tag_q.push_back("R5 pre-clear status");
        rd_en = 1'b1; tick(); rd_en = 1'b0;
        check("R6 irq released after read", {7'd0, irq_oe}, 8'h00);
        tick();
        read_stat(8'h00, "R6 status clear");

        // R7: an event that collides with a read is kept
        pulse(0, 1, 0);
        exp_q.push_back(8'hA0); tag_q.push_back("R7 collision read value");
        rd_en = 1'b1; ev_alarm = 1'b1;
        tick();
        rd_en = 1'b0; ev_alarm = 1'b0;
        check("R7 irq still set", {7'd0, irq_oe}, 8'h01);
        tick();
        read_stat(8'hA0, "R7 flag kept");
        read_stat(8'h00, "R7 then cleared");

        // R10: during power fail the hold does not clear, bus is blocked
        write_ctl(8'h78);
        pulse(1, 0, 0);
        pwr_ok = 1'b0; tick();
        hold_n = 1'b0; tick(); tick();
        write_ctl(8'h00);
        read_ignored("R10 read blocked");
        check("R10 enables kept", {4'd0, sqw_en, int_en}, 8'h0F);
        check("R10 irq kept", {7'd0, irq_oe}, 8'h01);
        hold_n = 1'b1; tick();
        pwr_ok = 1'b1; tick();
        read_stat(8'hC0, "R10 flags kept");

        // R8: the hold with power good clears; R9: bus blocked
        write_ctl(8'h78);
        pulse(0, 0, 1);
        check("R8 irq before hold", {7'd0, irq_oe}, 8'h01);
        hold_n = 1'b0; tick();
        check("R8 cleared", {4'd0, sqw_en, int_en}, 8'h00);
        check("R8 irq released", {7'd0, irq_oe}, 8'h00);
        write_ctl(8'h78);
        check("R9 write ignored", {4'd0, sqw_en, int_en}, 8'h00);
        read_ignored("R9 read blocked");
        pulse(1, 1, 1);
        hold_n = 1'b1; tick();
        read_stat(8'h00, "R8 flags cleared and held");

        tick(); tick();
        check("R5 scoreboard drained", exp_q.size(), 8'h00);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule